// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

This block drives an 18-channel output bus Y from an input bus A, through one storage path whose behaviour is picked at run time. With the mode control low the path is transparent and Y follows A in the same cycle. With the mode control high the path becomes a rising-edge register that captures A when an external data strobe rises, and holds it otherwise. An active-low output enable gates the whole bus into a high-impedance condition.

The block is a synchronous emulation running on a fast system clock. The external strobe is brought into the clock domain by a synchronizer, and its rising edge is found there. Y leaves the block as a data vector plus a drive-enable flag. A pad-level three-state driver can be built outside the block from these two signals.

There is no stream handshake at this block. A, Y and the controls are plain level signals, so there is no back-pressure. Any producer of A must keep it steady around a detected strobe edge.

Top module: `latreg_bus_driver`

## Requirements
- R1: While `oe_n` is 1, `y_drive` is 0 and `y_data` is all zeros, whatever `le`, `strobe` and `a_in` do.
- R2: While `oe_n` is 0 and `le` is 0, `y_drive` is 1 and `y_data` equals `a_in` in the same cycle, with no clock delay.
- R3: While `le` is 1, a 0-to-1 change of `strobe` captures the value `a_in` has at the third system-clock rising edge after the change. `y_data` shows that value from that edge on, and not before it.
- R4: While `le` is 1 and `strobe` stays steady, high or low, `y_data` keeps the stored value even when `a_in` changes.
- R5: When `le` goes from 0 to 1, `y_data` holds the value `a_in` had at the last system-clock edge before `le` rose, with no gap.
- R6: A 1-to-0 change of `strobe` while `le` is 1 stores nothing.
- R7: Storing does not depend on `oe_n`. A value captured while `oe_n` is 1 appears on `y_data` once `oe_n` returns to 0.
- R8: While `rst` is 1 at a clock edge, the stored value is cleared to zero, and `y_drive` is 0 during reset. After reset, with `le` = 1 and `oe_n` = 0, `y_data` reads zero.
- R9: When `le` falls back to 0 during a hold, `y_data` follows `a_in` again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Input data bus |
| oe_n | input | 1 | Output enable, active low; high gates Y off |
| le | input | 1 | Mode: 0 transparent, 1 edge-register |
| strobe | input | 1 | External data strobe, asynchronous to clk |
| y_data | output | 18 | Output data, zero when not driven |
| y_drive | output | 1 | 1 when Y is actively driven |

## Verification
The hardest case to reach from the ports is a capture that lands exactly on the third system-clock edge after the strobe rises. To reach it, the stimulus changes `a_in` on each cycle between the strobe change and that edge. Checking `y_data` on every one of those cycles shows that only the value present at the capture edge is taken.

A second hard case is a capture made while the bus is gated off. The stimulus captures a value with `oe_n` high, then releases `oe_n` and reads the stored value back. A third case raises `le` while `strobe` is already high and then lets `strobe` fall. This shows that the falling edge stores nothing.

// File: rtl/latreg_pkg.sv
package latreg_pkg;
  localparam int BUS_W       = 18;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_EDGE = 1'b1
  } path_mode_e;
endpackage

// File: rtl/strobe_rise_detect.sv
module strobe_rise_detect #(
  parameter int STAGES = latreg_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= strobe;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R3: an edge yields exactly one capture pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/hold_store.sv
module hold_store #(
  parameter int W = latreg_pkg::BUS_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  latreg_pkg::path_mode_e mode,
  input  logic                   rise,
  input  logic [W-1:0]           d,
  output logic [W-1:0]           q
);
  import latreg_pkg::*;

  logic load;
  assign load = (mode == MODE_PASS) || rise;

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R5: storage tracks A while transparent, so freezing is seamless
  a_r5_track: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PASS) |=> q == $past(d));
  // R3: a detected rise in edge mode takes the current A
  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_EDGE && rise) |=> q == $past(d));
  // R4: no rise in edge mode leaves storage untouched
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_EDGE && !rise) |=> $stable(q));
endmodule

// File: rtl/bus_out_gate.sv
module bus_out_gate #(
  parameter int W = latreg_pkg::BUS_W
) (
  input  logic                   rst,
  input  logic                   oe_n,
  input  latreg_pkg::path_mode_e mode,
  input  logic [W-1:0]           live,
  input  logic [W-1:0]           stored,
  output logic [W-1:0]           y_data,
  output logic                   y_drive
);
  import latreg_pkg::*;

  logic [W-1:0] chosen;

  always_comb begin
    chosen  = (mode == MODE_PASS) ? live : stored;
    y_drive = ~oe_n & ~rst;
    y_data  = y_drive ? chosen : '0;
  end
endmodule

// File: rtl/latreg_bus_driver.sv
module latreg_bus_driver #(
  parameter int W      = latreg_pkg::BUS_W,
  parameter int STAGES = latreg_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         oe_n,
  input  logic         le,
  input  logic         strobe,
  output logic [W-1:0] y_data,
  output logic         y_drive
);
  import latreg_pkg::*;

  path_mode_e   mode;
  logic         rise;
  logic [W-1:0] stored;

  assign mode = le ? MODE_EDGE : MODE_PASS;

  strobe_rise_detect #(.STAGES(STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .rise   (rise)
  );

  hold_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .rise (rise),
    .d    (a_in),
    .q    (stored)
  );

  bus_out_gate #(.W(W)) u_gate (
    .rst     (rst),
    .oe_n    (oe_n),
    .mode    (mode),
    .live    (a_in),
    .stored  (stored),
    .y_data  (y_data),
    .y_drive (y_drive)
  );

  // R1: a disabled bus is never driven and carries zeros
  a_r1_hiz: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!y_drive && y_data == '0));
  // R2: enabled and transparent, Y mirrors A
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !le) |-> (y_drive && y_data == a_in));
  // R4: enabled edge mode, Y only moves on the cycle after a rise
  a_r4_y_steady: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && le && !rise) |=> (!oe_n && le) |-> $stable(y_data));
endmodule

// File: tb/latreg_bus_driver_test.sv
module latreg_bus_driver_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in;
  logic         oe_n;
  logic         le;
  logic         strobe;
  logic [W-1:0] y_data;
  logic         y_drive;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  latreg_bus_driver uut (
    .clk(clk), .rst(rst), .a_in(a_in), .oe_n(oe_n),
    .le(le), .strobe(strobe), .y_data(y_data), .y_drive(y_drive)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [W-1:0] exp_d,
                       input logic exp_e);
    #0.5;
    n_run++;
    if (y_data !== exp_d || y_drive !== exp_e) begin
      n_fail++;
      $display("FAIL %s: y_data=%h y_drive=%b expected %h %b",
               tag, y_data, y_drive, exp_d, exp_e);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; oe_n = 1'b0; le = 1'b1; strobe = 1'b0; a_in = 18'h3FFFF;
    tick(); tick();
    check("R8 drive off in reset", '0, 1'b0);
    rst = 1'b0;
    tick();
    check("R8 stored zero after reset", '0, 1'b1);
  endtask

  task automatic t_pass();
    le = 1'b0; oe_n = 1'b0;
    a_in = 18'h12345; #1;
    check("R2 pass pattern A", 18'h12345, 1'b1);
    a_in = 18'h2AAAA; #1;
    check("R2 pass same cycle", 18'h2AAAA, 1'b1);
    tick();
    a_in = 18'h15555; #1;
    check("R2 pass pattern B", 18'h15555, 1'b1);
  endtask

  task automatic t_hiz();
    oe_n = 1'b1; le = 1'b0; a_in = 18'h3FFFF; #1;
    check("R1 hiz transparent", '0, 1'b0);
    le = 1'b1; strobe = 1'b1; tick(); tick();
    check("R1 hiz edge mode", '0, 1'b0);
    strobe = 1'b0; tick(); tick(); tick();
    oe_n = 1'b0; le = 1'b0; tick();
  endtask

  task automatic t_freeze();
    le = 1'b0; a_in = 18'h0BEEF; tick();
    le = 1'b1; #1;
    check("R5 freeze on le rise", 18'h0BEEF, 1'b1);
    a_in = 18'h00001; tick();
    check("R4 hold after freeze", 18'h0BEEF, 1'b1);
  endtask

  task automatic t_capture();
    a_in = 18'h11111; strobe = 1'b1;
    tick();
    a_in = 18'h22222;
    tick();
    check("R3 not yet at edge two", 18'h0BEEF, 1'b1);
    a_in = 18'h33333;
    tick();
    check("R3 capture at third edge", 18'h33333, 1'b1);
    a_in = 18'h04444;
    tick(); tick();
    check("R4 hold strobe high", 18'h33333, 1'b1);
  endtask

  task automatic t_fall();
    strobe = 1'b0; a_in = 18'h05050;
    repeat (5) tick();
    check("R6 no capture on fall", 18'h33333, 1'b1);
    a_in = 18'h06060; tick(); tick();
    check("R4 hold strobe low", 18'h33333, 1'b1);
  endtask

  task automatic t_le_fall_strobe_high();
    le = 1'b0; a_in = 18'h00ABC; strobe = 1'b1;
    repeat (4) tick();
    le = 1'b1; a_in = 18'h00DEF; tick();
    check("R5 freeze with strobe high", 18'h00ABC, 1'b1);
    strobe = 1'b0; repeat (5) tick();
    check("R6 fall after le rise", 18'h00ABC, 1'b1);
    le = 1'b0; #1;
    check("R9 le drop resumes pass", 18'h00DEF, 1'b1);
    tick();
  endtask

  task automatic t_capture_hidden();
    le = 1'b1; tick();
    oe_n = 1'b1; a_in = 18'h2C0DE; strobe = 1'b1;
    repeat (4) tick();
    check("R7 gated during capture", '0, 1'b0);
    a_in = 18'h00000; strobe = 1'b0; tick();
    oe_n = 1'b0; #1;
    check("R7 hidden capture shown", 18'h2C0DE, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_hiz();
    t_freeze();
    t_capture();
    t_fall();
    t_le_fall_strobe_high();
    t_capture_hidden();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule